// File: doc/BRIEF.md
# Multi-Channel Event Timer

A register-mapped timer peripheral built around one free-running 64-bit main counter and a set of comparator channels (three by default). Software reaches it through a plain 32-bit bus: byte address, write strobe, write data and combinational read data. The block decodes a set of global registers: identity and capability, tick period, configuration, status and the two halves of the main counter. It also decodes one register window per channel, holding that channel's configuration, capability and comparator.

The main counter advances once per cycle of the `tick_en` input while the global enable bit is set. It freezes when the bit is cleared and resumes from the frozen value. Software may load either 32-bit half of the counter without disturbing the other half. Each enabled channel raises a one-cycle pulse on one of the interrupt lines when the low word of the counter steps onto its comparator value. The channel's route field chooses the line. When the global legacy bit is set, the route field of the first two channels is overridden and they go to fixed lines instead.

Top module: `evt_timer_top`

## Requirements
- R1: After reset the main counter reads 0, the general configuration reads 0, every channel comparator reads 0xFFFFFFFF, every channel configuration reads 0 and all interrupt lines are low.
- R2: The word at 0x000 reads revision 0x01 in bits [7:0], the channel count minus one in bits [12:8], 0 in bit 13 (comparators are 32 bits wide), 1 in bit 15 (legacy routing supported) and the VENDOR_ID parameter in bits [31:16]; writes to it are ignored.
- R3: The word at 0x004 returns the TICK_PERIOD parameter, and the word at 0x014 returns zero.
- R4: In the general configuration at 0x010, only bit 0 (global enable) and bit 1 (legacy route) can be written; every other bit reads back as zero.
- R5: While global enable is set, the main counter increments by one at each clock edge where `tick_en` is high. While global enable is clear, it holds its value, and after enable is set again it continues from the held value.
- R6: A write to 0x0F0 replaces bits [31:0] of the counter, and a write to 0x0F4 replaces bits [63:32]. Each of these writes leaves the other half unchanged, and reads of the two addresses return the matching half.
- R7: Channel n's window starts at 0x100 + n*0x20. Its configuration is at +0x00, with bit 2 as the channel enable and bits [12:9] as the route; all other bits read zero. Its capability word is at +0x04 and is read-only, holding a mask of the routable lines (0x0000FFFF by default). Its comparator is at +0x08. Reads of +0x0C and +0x10 return zero.
- R8: When global enable and channel enable are both set, the interrupt line chosen by the route field is high for exactly one cycle. That cycle is the one in which the counter has just stepped to a value whose low word equals the comparator. No other line pulses.
- R9: With the legacy bit set, channel 0 pulses line 0 and channel 1 pulses line 8 whatever their route fields hold; the other channels keep their own route.
- R10: Reads of a channel window whose index is at or beyond the channel count return zero, and writes there change no implemented channel. Reads of unmapped offsets return zero, and writes to them have no effect.
- R11: With global enable clear, no interrupt line pulses even while `tick_en` is high and a channel is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance qualifier, one step per high cycle |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 16 | Interrupt lines, one-cycle pulses |

## Verification
Read data is combinational, so a register read is sampled in the same cycle the address is presented. A write takes effect at the clock edge during which the strobe is high, so the bench always reads it back in a later cycle. The counter moves at each edge where `tick_en` is high, so the bench holds that input high across a known number of edges and expects the count to change by exactly that amount. A channel pulse is registered at the same edge that moves the counter onto the comparator. The bench therefore samples the interrupt lines and the counter together just after each edge, and requires the pulse to appear only in the sample where the counter equals the comparator.

// File: rtl/evt_timer_pkg.sv
// Package: shared constants and address layout for the event timer.
// Assumes byte addresses with word-aligned 32-bit accesses only.
package evt_timer_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned CNT_W   = 64;
    localparam int unsigned ADDR_W  = 10;

    localparam logic [ADDR_W-1:0] A_IDENT   = 10'h000;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 10'h004;
    localparam logic [ADDR_W-1:0] A_GCFG    = 10'h010;
    localparam logic [ADDR_W-1:0] A_GCFG_HI = 10'h014;
    localparam logic [ADDR_W-1:0] A_STAT    = 10'h020;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 10'h0F0;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 10'h0F4;

    localparam logic [4:0] OFS_CFG  = 5'h00;
    localparam logic [4:0] OFS_CAP  = 5'h04;
    localparam logic [4:0] OFS_CMP  = 5'h08;

    localparam logic [7:0] REVISION = 8'h01;

    typedef struct packed {
        logic legacy;
        logic enable;
    } gcfg_t;
endpackage

// File: rtl/evt_main_counter.sv
// Module: 64-bit main counter with per-half load.
// Assumes at most one of load_lo/load_hi is high in a cycle; a load wins
// over a tick in the same cycle.
module evt_main_counter
    import evt_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             load_lo_i,
    input  logic             load_hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             step_o
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: decide whether this cycle advances the count.
    always_comb begin
        step_o    = run_i && tick_i && !load_lo_i && !load_hi_i;
        cnt_nxt_o = cnt_q + CNT_W'(1);
    end

    // Purpose: hold, load one half, or advance the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_lo_i) begin
            cnt_q[BUS_W-1:0] <= wdata_i;
        end else if (load_hi_i) begin
            cnt_q[CNT_W-1:BUS_W] <= wdata_i;
        end else if (step_o) begin
            cnt_q <= cnt_nxt_o;
        end
    end

    assign cnt_o = cnt_q;

    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_lo_i && !load_hi_i) |=> $stable(cnt_q));
    assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !load_lo_i && !load_hi_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    assert_lo_load_keeps_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo_i |=> (cnt_q[CNT_W-1:BUS_W] == $past(cnt_q[CNT_W-1:BUS_W])));
    assert_hi_load_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_hi_i |=> (cnt_q[BUS_W-1:0] == $past(cnt_q[BUS_W-1:0])));
endmodule

// File: rtl/evt_channel.sv
// Module: one comparator channel. Holds enable, route and comparator and
// emits a registered one-cycle pulse when the counter steps onto the match.
// Assumes the counter supplies its next value and a step qualifier.
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int unsigned ROUTE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cfg_i,
    input  logic               wr_cmp_i,
    input  logic [BUS_W-1:0]   wdata_i,
    input  logic               run_i,
    input  logic               step_i,
    input  logic [BUS_W-1:0]   cnt_nxt_lo_i,
    output logic [BUS_W-1:0]   cfg_rd_o,
    output logic [BUS_W-1:0]   cmp_o,
    output logic [ROUTE_W-1:0] route_o,
    output logic               fire_o
);
    localparam int unsigned ROUTE_LSB = 9;

    logic               en_q;
    logic [ROUTE_W-1:0] route_q;
    logic [BUS_W-1:0]   cmp_q;
    logic               fire_q;

    // Purpose: software-writable channel configuration and comparator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            route_q <= '0;
            cmp_q   <= '1;
        end else begin
            if (wr_cfg_i) begin
                en_q    <= wdata_i[2];
                route_q <= wdata_i[ROUTE_LSB +: ROUTE_W];
            end
            if (wr_cmp_i) begin
                cmp_q <= wdata_i;
            end
        end
    end

    // Purpose: register a pulse when the counter lands on the comparator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
        end else begin
            fire_q <= run_i && en_q && step_i && (cnt_nxt_lo_i == cmp_q);
        end
    end

    // Purpose: assemble the configuration read-back word.
    always_comb begin
        cfg_rd_o = '0;
        cfg_rd_o[2] = en_q;
        cfg_rd_o[ROUTE_LSB +: ROUTE_W] = route_q;
    end

    assign cmp_o   = cmp_q;
    assign route_o = route_q;
    assign fire_o  = fire_q;

    assert_fire_needs_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> $past(step_i && en_q && run_i));
    assert_fire_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q || $past(step_i));
    assert_no_fire_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !fire_q);
endmodule

// File: rtl/evt_irq_merge.sv
// Module: maps channel pulses onto interrupt lines, honouring the legacy
// override for channels 0 and 1. Assumes legacy lines are below NUM_IRQ.
module evt_irq_merge #(
    parameter int unsigned NUM_CH    = 3,
    parameter int unsigned NUM_IRQ   = 16,
    parameter int unsigned LEG0_LINE = 0,
    parameter int unsigned LEG1_LINE = 8,
    localparam int unsigned ROUTE_W  = $clog2(NUM_IRQ)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            legacy_i,
    input  logic [NUM_CH-1:0]               fire_i,
    input  logic [NUM_CH-1:0][ROUTE_W-1:0]  route_i,
    output logic [NUM_IRQ-1:0]              irq_o
);
    logic [NUM_CH-1:0][ROUTE_W-1:0] line;

    // Purpose: per-channel target line, with legacy override on the first two.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_line
        if (c == 0) begin : g_leg0
            assign line[c] = legacy_i ? ROUTE_W'(LEG0_LINE) : route_i[c];
        end else if (c == 1) begin : g_leg1
            assign line[c] = legacy_i ? ROUTE_W'(LEG1_LINE) : route_i[c];
        end else begin : g_plain
            assign line[c] = route_i[c];
        end
    end

    // Purpose: OR every firing channel onto its target line.
    always_comb begin
        irq_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (fire_i[c]) begin
                irq_o[line[c]] = 1'b1;
            end
        end
    end

    assert_quiet_without_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i == '0) |-> (irq_o == '0));
    assert_lines_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_o) <= $countones(fire_i));
endmodule

// File: rtl/evt_timer_top.sv
// Module: event timer top. Decodes the register bus, owns the global
// configuration, and connects counter, channels and interrupt merge.
// Assumes word-aligned 32-bit accesses; read data is combinational.
module evt_timer_top
    import evt_timer_pkg::*;
#(
    parameter int unsigned NUM_CH      = 3,
    parameter int unsigned NUM_IRQ     = 16,
    parameter logic [31:0] TICK_PERIOD = 32'h0098_9680,
    parameter logic [15:0] VENDOR_ID   = 16'h0001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [9:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_IRQ-1:0]  irq_o
);
    localparam int unsigned ROUTE_W  = $clog2(NUM_IRQ);
    localparam logic [ADDR_W-1:0] CH_BASE = 10'h100;
    localparam logic [31:0] ROUTE_CAP = 32'((64'd1 << NUM_IRQ) - 64'd1);

    gcfg_t                          gcfg_q;
    logic [CNT_W-1:0]               cnt, cnt_nxt;
    logic                           step;
    logic                           ch_hit;
    logic [4:0]                     ch_idx;
    logic [4:0]                     ch_ofs;
    logic [NUM_CH-1:0]              wr_cfg, wr_cmp, fire;
    logic [NUM_CH-1:0][BUS_W-1:0]   cfg_rd, cmp_rd;
    logic [NUM_CH-1:0][ROUTE_W-1:0] route;
    logic [BUS_W-1:0]               ident;

    // Purpose: split a channel-window address into index and offset.
    always_comb begin
        ch_hit = (bus_addr >= CH_BASE);
        ch_idx = 5'((bus_addr - CH_BASE) >> 5);
        ch_ofs = bus_addr[4:0];
        ident  = {VENDOR_ID, 1'b1, 1'b0, 1'b0, 5'(NUM_CH - 1), REVISION};
    end

    // Purpose: global configuration, only enable and legacy are writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg_q <= '0;
        end else if (bus_wr && bus_addr == A_GCFG) begin
            gcfg_q <= gcfg_t'(bus_wdata[1:0]);
        end
    end

    evt_main_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (gcfg_q.enable),
        .tick_i    (tick_en),
        .load_lo_i (bus_wr && bus_addr == A_CNT_LO),
        .load_hi_i (bus_wr && bus_addr == A_CNT_HI),
        .wdata_i   (bus_wdata),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt),
        .step_o    (step)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign wr_cfg[c] = bus_wr && ch_hit && ch_idx == 5'(c) && ch_ofs == OFS_CFG;
        assign wr_cmp[c] = bus_wr && ch_hit && ch_idx == 5'(c) && ch_ofs == OFS_CMP;

        evt_channel #(.ROUTE_W(ROUTE_W)) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_cfg_i     (wr_cfg[c]),
            .wr_cmp_i     (wr_cmp[c]),
            .wdata_i      (bus_wdata),
            .run_i        (gcfg_q.enable),
            .step_i       (step),
            .cnt_nxt_lo_i (cnt_nxt[BUS_W-1:0]),
            .cfg_rd_o     (cfg_rd[c]),
            .cmp_o        (cmp_rd[c]),
            .route_o      (route[c]),
            .fire_o       (fire[c])
        );
    end

    evt_irq_merge #(
        .NUM_CH  (NUM_CH),
        .NUM_IRQ (NUM_IRQ)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .legacy_i (gcfg_q.legacy),
        .fire_i   (fire),
        .route_i  (route),
        .irq_o    (irq_o)
    );

    // Purpose: read multiplexer; anything unmapped returns zero.
    always_comb begin
        bus_rdata = '0;
        if (ch_hit) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_idx == 5'(c)) begin
                    case (ch_ofs)
                        OFS_CFG: bus_rdata = cfg_rd[c];
                        OFS_CAP: bus_rdata = ROUTE_CAP;
                        OFS_CMP: bus_rdata = cmp_rd[c];
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end else begin
            case (bus_addr)
                A_IDENT:   bus_rdata = ident;
                A_PERIOD:  bus_rdata = TICK_PERIOD;
                A_GCFG:    bus_rdata = {30'b0, gcfg_q};
                A_CNT_LO:  bus_rdata = cnt[BUS_W-1:0];
                A_CNT_HI:  bus_rdata = cnt[CNT_W-1:BUS_W];
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_gcfg_write_only_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_GCFG) |=> (gcfg_q == gcfg_t'($past(bus_wdata[1:0]))));
    assert_gcfg_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_GCFG) |=> $stable(gcfg_q));
endmodule

// File: tb/evt_timer_top_tb_top.sv
// Directed bench for the event timer: one task per scenario.
module evt_timer_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int k);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (k) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        rd(10'h0F0, d); chk("R1 counter", d, 32'h0);
        rd(10'h010, d); chk("R1 config", d, 32'h0);
        for (int c = 0; c < 3; c++) begin
            rd(10'(10'h108 + c*32), d); chk("R1 comparator", d, 32'hFFFF_FFFF);
            rd(10'(10'h100 + c*32), d); chk("R1 channel config", d, 32'h0);
        end
        chk("R1 irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_ident_regs();
        logic [31:0] d;
        rd(10'h000, d); chk("R2 ident", d, 32'h0001_8201);
        wr(10'h000, 32'h1234_5678);
        rd(10'h000, d); chk("R2 ident write ignored", d, 32'h0001_8201);
        rd(10'h004, d); chk("R3 period", d, 32'h0098_9680);
        rd(10'h014, d); chk("R3 config high", d, 32'h0);
    endtask

    task automatic t_gcfg_bits();
        logic [31:0] d;
        wr(10'h010, 32'hFFFF_FFFF);
        rd(10'h010, d); chk("R4 writable bits", d, 32'h3);
        wr(10'h010, 32'h0);
        rd(10'h010, d); chk("R4 cleared", d, 32'h0);
    endtask

    task automatic t_counter_run();
        logic [31:0] d;
        wr(10'h0F0, 32'd100);
        ticks(5);
        rd(10'h0F0, d); chk("R5 hold while disabled", d, 32'd100);
        wr(10'h010, 32'h1);
        ticks(7);
        rd(10'h0F0, d); chk("R5 count 7 ticks", d, 32'd107);
        wr(10'h010, 32'h0);
        ticks(4);
        rd(10'h0F0, d); chk("R5 frozen", d, 32'd107);
        wr(10'h010, 32'h1);
        ticks(3);
        rd(10'h0F0, d); chk("R5 resume from held", d, 32'd110);
        wr(10'h010, 32'h0);
    endtask

    task automatic t_counter_halves();
        logic [31:0] d;
        wr(10'h0F0, 32'hAAAA_5555);
        wr(10'h0F4, 32'h1357_2468);
        rd(10'h0F0, d); chk("R6 low kept", d, 32'hAAAA_5555);
        rd(10'h0F4, d); chk("R6 high", d, 32'h1357_2468);
        wr(10'h0F0, 32'hFFFF_FFFE);
        rd(10'h0F4, d); chk("R6 high kept", d, 32'h1357_2468);
        wr(10'h010, 32'h1);
        ticks(3);
        wr(10'h010, 32'h0);
        rd(10'h0F0, d); chk("R6 low wrap", d, 32'h1);
        rd(10'h0F4, d); chk("R6 carry into high", d, 32'h1357_2469);
    endtask

    task automatic t_channel_regs();
        logic [31:0] d;
        wr(10'h120, 32'hFFFF_FFFF);
        rd(10'h120, d); chk("R7 channel config mask", d, 32'h0000_1E04);
        rd(10'h124, d); chk("R7 channel capability", d, 32'h0000_FFFF);
        wr(10'h124, 32'h0);
        rd(10'h124, d); chk("R7 capability read-only", d, 32'h0000_FFFF);
        wr(10'h128, 32'hCAFE_0001);
        rd(10'h128, d); chk("R7 comparator", d, 32'hCAFE_0001);
        rd(10'h12C, d); chk("R7 comparator high zero", d, 32'h0);
        rd(10'h130, d); chk("R7 route word zero", d, 32'h0);
        wr(10'h120, 32'h0);
        wr(10'h128, 32'hFFFF_FFFF);
    endtask

    // Run ticks and watch one line; expect one pulse exactly when counter == at.
    task automatic watch_pulse(input string req, input int line, input logic [31:0] at, input int cyc);
        int hits = 0;
        int bad = 0;
        logic [31:0] cnt_at = '0;
        @(negedge clk);
        bus_addr = 10'h0F0;
        tick_en = 1'b1;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk);
            #1;
            if (irq_o[line]) begin hits++; cnt_at = bus_rdata; end
            if ((irq_o & ~(16'd1 << line)) != 16'h0) bad++;
        end
        @(negedge clk);
        tick_en = 1'b0;
        chk({req, " pulse count"}, 32'(hits), 32'd1);
        chk({req, " counter at pulse"}, cnt_at, at);
        chk({req, " other lines quiet"}, 32'(bad), 32'd0);
    endtask

    task automatic t_irq_route();
        wr(10'h0F0, 32'd10);
        wr(10'h0F4, 32'd0);
        wr(10'h108, 32'd13);
        wr(10'h100, (32'd5 << 9) | 32'h4);
        wr(10'h010, 32'h1);
        watch_pulse("R8 route 5", 5, 32'd13, 8);
        wr(10'h010, 32'h0);
        wr(10'h100, 32'h0);
    endtask

    task automatic t_irq_legacy();
        wr(10'h0F0, 32'd50);
        wr(10'h108, 32'd53);
        wr(10'h100, (32'd5 << 9) | 32'h4);
        wr(10'h010, 32'h3);
        watch_pulse("R9 channel 0 legacy", 0, 32'd53, 6);
        wr(10'h010, 32'h0);
        wr(10'h100, 32'h0);
        wr(10'h0F0, 32'd70);
        wr(10'h128, 32'd72);
        wr(10'h120, (32'd3 << 9) | 32'h4);
        wr(10'h010, 32'h3);
        watch_pulse("R9 channel 1 legacy", 8, 32'd72, 6);
        wr(10'h010, 32'h0);
        wr(10'h0F0, 32'd70);
        wr(10'h010, 32'h1);
        watch_pulse("R9 channel 1 normal route", 3, 32'd72, 6);
        wr(10'h010, 32'h0);
        wr(10'h120, 32'h0);
    endtask

    task automatic t_no_irq_disabled();
        int seen = 0;
        wr(10'h0F0, 32'd20);
        wr(10'h148, 32'd21);
        wr(10'h140, (32'd6 << 9) | 32'h4);
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            if (irq_o != 16'h0) seen++;
        end
        @(negedge clk);
        tick_en = 1'b0;
        chk("R11 no pulse while disabled", 32'(seen), 32'd0);
        wr(10'h140, 32'h0);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        wr(10'h168, 32'h0000_0042);
        wr(10'h160, 32'hFFFF_FFFF);
        rd(10'h168, d); chk("R10 channel 3 reads zero", d, 32'h0);
        rd(10'h164, d); chk("R10 channel 3 capability zero", d, 32'h0);
        for (int c = 0; c < 3; c++) begin
            rd(10'(10'h108 + c*32), d); chk("R10 comparators untouched", d, 32'hFFFF_FFFF);
            rd(10'(10'h100 + c*32), d); chk("R10 configs untouched", d, 32'h0);
        end
        wr(10'h050, 32'hFFFF_FFFF);
        rd(10'h050, d); chk("R10 unmapped reads zero", d, 32'h0);
        rd(10'h010, d); chk("R10 unmapped write no effect", d, 32'h0);
        rd(10'h020, d); chk("R10 status reads zero", d, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_ident_regs();
        t_gcfg_bits();
        t_counter_run();
        t_counter_halves();
        t_channel_regs();
        t_irq_route();
        t_irq_legacy();
        t_no_irq_disabled();
        do_reset();
        t_out_of_range();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule